// File: doc/BRIEF.md
# SONET Transmit Overhead Regenerator

This block sits in the transmit path of a byte-wide STS-12 stream that runs in transparent mode. Each input byte comes with a one-cycle byte strobe. A frame-start marker flags the first framing byte. An internal row/column counter follows the position of every byte in a 9-row by 1080-column frame. The counter keeps running from one frame to the next without the marker, and a new marker re-aligns it at any time.

The block rewrites a few transport-overhead bytes and copies the rest. Framing bytes are always regenerated. Only the first STS-1 gets a freshly computed section parity byte, and the parity slots of the other eleven STS-1s are cleared. All remaining overhead and payload bytes are copied unchanged. The frame is then scrambled with a frame-synchronous scrambler.

The result leaves the block in two forms. One is a registered byte, with a valid flag and a frame-start flag. The other is a bit stream for a serial link, sent most significant bit first at one bit per clock. The byte strobe therefore runs at one eighth of the clock rate.

Top module: `sonet_tx_toh_regen`

## Requirements
- R1: When locked, the bytes at row 0, columns 0 to 11, are output as 0xF6, whatever value arrives on the input.
- R2: When locked, the bytes at row 0, columns 12 to 23, are output as 0x28, whatever value arrives on the input.
- R3: Before scrambling, the byte at row 1, column 0 is replaced by the even bit-interleaved parity (bitwise XOR) of all scrambled output bytes of the previous frame. In the first frame after lock this value is 0x00.
- R4: Before scrambling, the bytes at row 1, columns 1 to 11, are replaced by 0x00.
- R5: Every other byte, overhead or payload, is copied from input to output unaltered before scrambling. This includes the pointer action byte, which carries 0x00 when no justification occurs.
- R6: Row 0, columns 0 to 35, are sent unscrambled. Every other byte is XORed with a scrambler sequence from x^7+x^6+1. The scrambler is seeded with all ones at row 0, column 36, so the first key byte is 0xFE. Within each byte, bit 7 takes the first sequence bit.
- R7: A frame-start marker given with a byte strobe places that byte at row 0, column 0. Without a marker, the position advances by one column per byte, wraps after column 1079 to the next row, and wraps after row 8 to row 0, column 0.
- R8: Until the first frame-start marker after reset, each output byte equals its input byte, with no regeneration and no scrambling.
- R9: The cycle after a byte strobe, the serial output shows bit 7 of the new output byte and the serial-valid flag is high. The remaining bits follow in descending order, one per clock, with bit 0 in the eighth cycle. If no strobe comes after the eighth cycle, serial-valid falls.
- R10: The output byte, its valid flag and its frame-start flag update in the cycle after a byte strobe. Valid is high only for that one cycle. The frame-start flag is high when the byte was at row 0, column 0. After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_en | input | 1 | Byte strobe; at most one in any 8 cycles |
| sof_in | input | 1 | Frame-start marker, sampled with byte_en |
| din | input | 8 | Input byte in transmission order |
| dout | output | 8 | Regenerated and scrambled byte |
| dout_vld | output | 1 | dout updated this cycle |
| dout_sof | output | 1 | dout is row 0, column 0 |
| ser_bit | output | 1 | Serial bit, MSB of each byte first |
| ser_vld | output | 1 | ser_bit carries a bit of a byte |

## Verification
The assertions assume that byte strobes are at least eight cycles apart, so that each serial slot finishes before the next byte loads. They also assume that the frame-start marker matters only together with a strobe. The stimulus keeps to both rules. It drives a strobe on every eighth clock edge, raises the marker only in a strobe cycle, and changes inputs only on the falling edge.

The run covers the following cases:
- a stretch of unlocked bytes;
- a marked frame;
- a full frame found only by the counter's wrap;
- a marker in the middle of a frame, which re-aligns the counter and closes a partial parity window.

// File: rtl/sonet_toh_pkg.sv
package sonet_toh_pkg;

  localparam logic [7:0] A1_VAL = 8'hF6;
  localparam logic [7:0] A2_VAL = 8'h28;
  localparam logic [6:0] SCR_SEED = 7'h7F;

  typedef struct packed {
    logic [6:0] st;
    logic [7:0] ks;
  } scr_step_t;

  // Advance the x^7+x^6+1 generator by eight bits; first bit lands in bit 7.
  function automatic scr_step_t scr_advance(input logic [6:0] st_in);
    scr_step_t r;
    logic [6:0] s;
    s = st_in;
    r.ks = '0;
    for (int i = 7; i >= 0; i--) begin
      r.ks[i] = s[6];
      s = {s[5:0], s[6] ^ s[5]};
    end
    r.st = s;
    return r;
  endfunction

  // Pre-scramble byte value for a given frame position.
  function automatic logic [7:0] toh_regen(input int unsigned row, input int unsigned col,
                                           input int unsigned n, input logic [7:0] d,
                                           input logic [7:0] b1);
    logic [7:0] v;
    v = d;
    if (row == 0 && col < n) v = A1_VAL;
    else if (row == 0 && col < 2 * n) v = A2_VAL;
    else if (row == 1 && col == 0) v = b1;
    else if (row == 1 && col < n) v = 8'h00;
    return v;
  endfunction

endpackage

// File: rtl/sonet_frame_pos.sv
module sonet_frame_pos #(
  parameter int ROWS = 9,
  parameter int COLS = 1080,
  parameter int ROWW = $clog2(ROWS),
  parameter int COLW = $clog2(COLS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            byte_en,
  input  logic            sof_in,
  output logic [ROWW-1:0] cur_row,
  output logic [COLW-1:0] cur_col,
  output logic            cur_vld,
  output logic            frame_wrap
);
  localparam logic [ROWW-1:0] LAST_ROW = ROWW'(ROWS - 1);
  localparam logic [COLW-1:0] LAST_COL = COLW'(COLS - 1);

  logic            locked;
  logic [ROWW-1:0] nxt_row;
  logic [COLW-1:0] nxt_col;
  logic            step;

  assign cur_vld    = locked | sof_in;
  assign cur_row    = sof_in ? '0 : nxt_row;
  assign cur_col    = sof_in ? '0 : nxt_col;
  assign step       = byte_en & cur_vld;
  assign frame_wrap = step & (cur_row == '0) & (cur_col == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked  <= 1'b0;
      nxt_row <= '0;
      nxt_col <= '0;
    end else if (step) begin
      locked <= 1'b1;
      if (cur_col == LAST_COL) begin
        nxt_col <= '0;
        nxt_row <= (cur_row == LAST_ROW) ? '0 : cur_row + 1'b1;
      end else begin
        nxt_col <= cur_col + 1'b1;
        nxt_row <= cur_row;
      end
    end
  end

  // R7: the last byte of a frame is followed by row 0, column 0
  a_r7_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    step && cur_row == LAST_ROW && cur_col == LAST_COL |=> cur_row == '0 && cur_col == '0);

  // R7: a marked byte locks the counter
  a_r7_sof_lock: assert property (@(posedge clk) disable iff (!rst_n)
    byte_en && sof_in |=> cur_vld);

endmodule

// File: rtl/sonet_scrambler.sv
module sonet_scrambler #(
  parameter int N      = 12,
  parameter int ROWW   = 4,
  parameter int COLW   = 11,
  parameter bit ENABLE = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic [ROWW-1:0] cur_row,
  input  logic [COLW-1:0] cur_col,
  input  logic [7:0]      pre,
  output logic [7:0]      scr_byte
);
  import sonet_toh_pkg::*;

  localparam logic [COLW-1:0] TOH_COL = COLW'(3 * N);

  generate
    if (ENABLE) begin : g_scr
      logic [6:0] st;
      logic [6:0] st_use;
      logic       seed_here;
      logic       skip;
      scr_step_t  nx;

      assign seed_here = (cur_row == '0) && (cur_col == TOH_COL);
      assign skip      = (cur_row == '0) && (cur_col < TOH_COL);
      assign st_use    = seed_here ? SCR_SEED : st;
      assign nx        = scr_advance(st_use);
      assign scr_byte  = skip ? pre : (pre ^ nx.ks);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SCR_SEED;
        else if (adv && !skip) st <= nx.st;
      end

      // R6: generator never locks up in the all-zero state
      a_r6_nonzero: assert property (@(posedge clk) disable iff (!rst_n) st != 7'h00);
    end else begin : g_pass
      logic unused_ok;
      assign unused_ok = &{1'b0, clk, rst_n, adv, cur_row, cur_col};
      assign scr_byte  = pre;
    end
  endgenerate

endmodule

// File: rtl/sonet_bip8.sv
module sonet_bip8 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       frame_wrap,
  input  logic [7:0] out_byte,
  output logic [7:0] b1_val
);
  logic [7:0] acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      b1_val <= '0;
    end else if (step) begin
      if (frame_wrap) begin
        b1_val <= acc;
        acc    <= out_byte;
      end else begin
        acc <= acc ^ out_byte;
      end
    end
  end

  // R3: parity value changes only at a frame boundary
  a_r3_b1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_wrap |=> $stable(b1_val));

endmodule

// File: rtl/sonet_ser_msb.sv
module sonet_ser_msb #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         ser_bit,
  output logic         ser_vld
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  sh;
  logic [CW-1:0] cnt;

  assign ser_bit = sh[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      cnt     <= '0;
      ser_vld <= 1'b0;
    end else if (load) begin
      sh      <= din;
      cnt     <= CW'(W - 1);
      ser_vld <= 1'b1;
    end else if (cnt != '0) begin
      sh  <= sh << 1;
      cnt <= cnt - 1'b1;
    end else begin
      ser_vld <= 1'b0;
    end
  end

  // R9: a loaded byte shows its MSB first
  a_r9_load_msb: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ser_vld && ser_bit == $past(din[W-1]));

endmodule

// File: rtl/sonet_tx_toh_regen.sv
module sonet_tx_toh_regen #(
  parameter int N        = 12,
  parameter int ROWS     = 9,
  parameter bit SCRAMBLE = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_en,
  input  logic       sof_in,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       dout_vld,
  output logic       dout_sof,
  output logic       ser_bit,
  output logic       ser_vld
);
  import sonet_toh_pkg::*;

  localparam int COLS     = 90 * N;
  localparam int TOH_COLS = 3 * N;
  localparam int ROWW     = $clog2(ROWS);
  localparam int COLW     = $clog2(COLS);
  localparam logic [COLW-1:0] C_A2  = COLW'(N);
  localparam logic [COLW-1:0] C_TOH = COLW'(TOH_COLS);

  logic [ROWW-1:0] cur_row;
  logic [COLW-1:0] cur_col;
  logic            cur_vld;
  logic            frame_wrap;
  logic            step;
  logic [7:0]      b1_val;
  logic [7:0]      pre;
  logic [7:0]      scr_byte;
  logic [7:0]      byte_nxt;

  // named position events for the assertions
  logic a1_slot, a2_slot;
  assign step    = byte_en & cur_vld;
  assign a1_slot = step && cur_row == '0 && cur_col < C_A2;
  assign a2_slot = step && cur_row == '0 && cur_col >= C_A2 && cur_col < (C_A2 << 1);

  sonet_frame_pos #(.ROWS(ROWS), .COLS(COLS), .ROWW(ROWW), .COLW(COLW)) u_pos (
    .clk(clk), .rst_n(rst_n), .byte_en(byte_en), .sof_in(sof_in),
    .cur_row(cur_row), .cur_col(cur_col), .cur_vld(cur_vld), .frame_wrap(frame_wrap)
  );

  assign pre = toh_regen(32'(cur_row), 32'(cur_col), N, din, b1_val);

  sonet_scrambler #(.N(N), .ROWW(ROWW), .COLW(COLW), .ENABLE(SCRAMBLE)) u_scr (
    .clk(clk), .rst_n(rst_n), .adv(step), .cur_row(cur_row), .cur_col(cur_col),
    .pre(pre), .scr_byte(scr_byte)
  );

  assign byte_nxt = cur_vld ? scr_byte : din;

  sonet_bip8 u_bip (
    .clk(clk), .rst_n(rst_n), .step(step), .frame_wrap(frame_wrap),
    .out_byte(byte_nxt), .b1_val(b1_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout     <= '0;
      dout_vld <= 1'b0;
      dout_sof <= 1'b0;
    end else begin
      dout_vld <= byte_en;
      dout_sof <= frame_wrap;
      if (byte_en) dout <= byte_nxt;
    end
  end

  sonet_ser_msb #(.W(8)) u_ser (
    .clk(clk), .rst_n(rst_n), .load(byte_en), .din(byte_nxt),
    .ser_bit(ser_bit), .ser_vld(ser_vld)
  );

  // R1: framing byte A1 regenerated
  a_r1_a1_regen: assert property (@(posedge clk) disable iff (!rst_n)
    a1_slot |=> dout == A1_VAL);

  // R2: framing byte A2 regenerated
  a_r2_a2_regen: assert property (@(posedge clk) disable iff (!rst_n)
    a2_slot |=> dout == A2_VAL);

  // R8: unlocked bytes pass straight through
  a_r8_unlocked_pass: assert property (@(posedge clk) disable iff (!rst_n)
    byte_en && !cur_vld |=> dout == $past(din));

  // R10: valid is a one-cycle echo of the strobe
  a_r10_vld_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_en |=> !dout_vld);

  // R9: serial output starts with the MSB of the byte register
  a_r9_ser_matches: assert property (@(posedge clk) disable iff (!rst_n)
    byte_en |=> ser_vld && ser_bit == dout[7]);

  generate
    if (SCRAMBLE) begin : g_chk_seed
      // R6: first scrambled byte uses key 0xFE
      a_r6_seed_key: assert property (@(posedge clk) disable iff (!rst_n)
        step && cur_row == '0 && cur_col == C_TOH |=> dout == ($past(din) ^ 8'hFE));
    end
  endgenerate

endmodule

// File: tb/tb_sonet_tx_toh_regen.sv
module tb_sonet_tx_toh_regen;
  localparam int N    = 12;
  localparam int ROWS = 9;
  localparam int COLS = 90 * N;
  localparam int TC   = 3 * N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_en = 1'b0;
  logic sof_in = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic dout_vld, dout_sof, ser_bit, ser_vld;

  always #5 clk = ~clk;

  sonet_tx_toh_regen dut (
    .clk(clk), .rst_n(rst_n), .byte_en(byte_en), .sof_in(sof_in), .din(din),
    .dout(dout), .dout_vld(dout_vld), .dout_sof(dout_sof),
    .ser_bit(ser_bit), .ser_vld(ser_vld)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model state
  bit         seq [0:126];
  bit         m_locked = 0;
  int         m_row = 0, m_col = 0, m_ph = 0;
  logic [7:0] m_acc = 8'h00, m_b1 = 8'h00;
  logic [31:0] rs = 32'h1234_5678;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] next_rand();
    rs = rs * 32'd1103515245 + 32'd12345;
    return rs[23:16];
  endfunction

  task automatic model(input logic [7:0] d, input bit s, output logic [7:0] o,
                       output bit osof, output string tag);
    int r, c;
    logic [7:0] pre;
    if (!(s || m_locked)) begin
      o = d; osof = 0; tag = "R8";
      return;
    end
    r = s ? 0 : m_row;
    c = s ? 0 : m_col;
    osof = (r == 0 && c == 0);
    if (osof) begin m_b1 = m_acc; m_acc = 8'h00; end
    pre = d; tag = "R5 R6";
    if (r == 0 && c < N)            begin pre = 8'hF6; tag = "R1"; end
    else if (r == 0 && c < 2 * N)   begin pre = 8'h28; tag = "R2"; end
    else if (r == 1 && c == 0)      begin pre = m_b1;  tag = "R3"; end
    else if (r == 1 && c < N)       begin pre = 8'h00; tag = "R4"; end
    o = pre;
    if (!(r == 0 && c < TC)) begin
      if (r == 0 && c == TC) m_ph = 0;
      for (int k = 7; k >= 0; k--) begin
        o[k] = pre[k] ^ seq[m_ph];
        m_ph = (m_ph + 1) % 127;
      end
    end
    m_acc = m_acc ^ o;
    c++;
    if (c == COLS) begin c = 0; r = (r == ROWS - 1) ? 0 : r + 1; end
    m_row = r; m_col = c; m_locked = 1;
  endtask

  task automatic send(input logic [7:0] d, input bit s);
    logic [7:0] e;
    bit es;
    string tg;
    @(negedge clk);
    byte_en = 1'b1; din = d; sof_in = s;
    model(d, s, e, es, tg);
    @(negedge clk);
    byte_en = 1'b0; sof_in = 1'b0;
    check(dout === e, tg, 32'(dout), 32'(e));
    check(dout_vld === 1'b1 && dout_sof === es, "R10 R7", {30'd0, dout_vld, dout_sof}, {30'd0, 1'b1, es});
    check(ser_vld === 1'b1 && ser_bit === e[7], "R9", {31'd0, ser_bit}, {31'd0, e[7]});
    for (int k = 6; k >= 0; k--) begin
      @(negedge clk);
      check(ser_vld === 1'b1 && ser_bit === e[k], "R9", {31'd0, ser_bit}, {31'd0, e[k]});
      check(dout_vld === 1'b0, "R10", {31'd0, dout_vld}, 32'd0);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int resync_at;
    for (int i = 0; i < 7; i++) seq[i] = 1'b1;
    for (int i = 7; i < 127; i++) seq[i] = seq[i - 7] ^ seq[i - 6];

    repeat (3) @(negedge clk);
    // R10: reset state
    check(dout === 8'h00 && dout_vld === 1'b0 && dout_sof === 1'b0, "R10",
          {22'd0, dout, dout_vld, dout_sof}, 32'd0);
    check(ser_vld === 1'b0, "R10 R9", {31'd0, ser_vld}, 32'd0);
    rst_n = 1'b1;

    // R8: unlocked stretch; R7: marked frame, wrapped frame, mid-frame re-align
    resync_at = 10 + 2 * ROWS * COLS + 300;
    for (int i = 0; i < resync_at + 200; i++)
      send(next_rand(), (i == 10) || (i == resync_at));

    // R9, R10: idle after the last byte
    @(negedge clk);
    check(ser_vld === 1'b0, "R9", {31'd0, ser_vld}, 32'd0);
    check(dout_vld === 1'b0, "R10", {31'd0, dout_vld}, 32'd0);
    finish_run();
  end

endmodule